// File: doc/BRIEF.md
# Dual-Channel Transmit Frame Buffer

This block is the transmit half of a small Ethernet MAC driven by programmed I/O. Software fills one of two byte buffers through a 32-bit data port and tells the block how many bytes make up the frame. A send command then streams those bytes, one per handshake, out of a byte-wide valid/ready port toward the line-side logic. Preamble, frame check sequence and the physical interface are handled elsewhere.

Each channel has its own buffer, its own length register, its own send command and its own completion status bit. A global enable gates every send command. A single interrupt line is raised while any completion bit is set and its enable bit is on. When a frame has left, its channel is emptied and its length cleared, so software can refill that channel while the other one is being loaded or sent.

All register access is write-only. A write is one cycle with `wr_en` high. The buffer depth is a parameter `DEPTH` (a power of two, at least 4, default 16).

Top module: `dual_tx_fifo`

## Requirements
- R1: A write to address 4 appends four bytes to the selected channel's buffer, bits 7:0 first and bits 31:24 last, and the frame is sent in that byte order.
- R2: A write to address 4 is discarded whole when the selected buffer has fewer than 4 free bytes. Bytes already held are unchanged.
- R3: A write to address 1 selects channel `wr_data[0]` when `wr_data` is 0 or 1. Any larger value selects channel 0.
- R4: A write to address 2 (channel 0) or address 3 (channel 1) sets that channel's frame length. A value above `DEPTH` is stored as `DEPTH`.
- R5: A write to address 5 (channel 0) or address 6 (channel 1) with `wr_data[0]=1` starts a send only when the enable bit (address 0, bit 0) is 1. Otherwise nothing is sent and the buffer keeps its contents.
- R6: A send emits the smaller of the frame length and the number of bytes held. When that number is 0, nothing is emitted, the status bit is not set and the buffer keeps its contents.
- R7: When the last byte of a frame is accepted, that channel's buffer is emptied, its length becomes 0 and its status bit is set.
- R8: `irq` is high exactly when some channel c has both status bit c and enable bit c set. The enable bits are written at address 7, bits 1:0. Writing 1 to bit c at address 8 clears status bit c, and a completion in the same cycle wins.
- R9: A send command that arrives while a frame is being emitted is ignored on either channel.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R11: After reset, `tx_valid` and `irq` are low, both buffers are empty, both lengths and status bits are 0, the enable is off and channel 0 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| tx_ready | input | 1 | Downstream accepts a byte |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | `tx_data` carries a frame byte |
| irq | output | 1 | Completion interrupt |

## Verification
The bench overfills a buffer and then sets a length far above capacity. A design that wraps on overflow would corrupt the first bytes, and one that truncates the length to its register width would send only a few bytes. It sends with the length above or below the held byte count, with a zero length, with the enable off, and a second time after a completion. A design that forgets to flush or to gate would put stray bytes on the stream or set a status bit. It issues a send on the idle channel while the other channel is stalled mid-frame. A design without a busy guard would switch channels or set the wrong status bit. It also writes channel-select values of 2 and above, and checks interrupt masking and clearing for each channel on its own.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

    localparam int NCH = 2;

    typedef enum logic [3:0] {
        A_CTRL  = 4'd0,
        A_CHSEL = 4'd1,
        A_LEN0  = 4'd2,
        A_LEN1  = 4'd3,
        A_DATA  = 4'd4,
        A_SEND0 = 4'd5,
        A_SEND1 = 4'd6,
        A_IEN   = 4'd7,
        A_ICLR  = 4'd8
    } reg_addr_e;

endpackage

// File: rtl/dtx_byte_fifo.sv
module dtx_byte_fifo #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [31:0]      push_word,
    input  logic             pop,
    input  logic             flush,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PTR_W-1:0]      rp;
        logic [PTR_W-1:0]      wp;
        logic [CNT_W-1:0]      cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     room_ok;
    logic     push_ok;

    always_comb begin
        st_d    = st_q;
        room_ok = (st_q.cnt <= CNT_W'(DEPTH - 4));
        push_ok = push && room_ok;
        if (flush) begin
            st_d.rp  = '0;
            st_d.wp  = '0;
            st_d.cnt = '0;
        end else begin
            if (push_ok) begin
                for (int k = 0; k < 4; k++) begin
                    st_d.mem[st_q.wp + PTR_W'(k)] = push_word[8*k +: 8];
                end
                st_d.wp = st_q.wp + PTR_W'(4);
            end
            if (pop) begin
                st_d.rp = st_q.rp + PTR_W'(1);
            end
            st_d.cnt = st_q.cnt + (push_ok ? CNT_W'(4) : CNT_W'(0))
                                - (pop ? CNT_W'(1) : CNT_W'(0));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;

endmodule

// File: rtl/dtx_sender.sv
module dtx_sender
    import dtx_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0]            send_req,
    input  logic [NCH-1:0][CNT_W-1:0] len,
    input  logic [NCH-1:0][CNT_W-1:0] held,
    input  logic [NCH-1:0][7:0]       head,
    input  logic                      tx_ready,
    output logic                      tx_valid,
    output logic [7:0]                tx_data,
    output logic [NCH-1:0]            pop,
    output logic [NCH-1:0]            done,
    output logic                      cur_ch
);

    typedef struct packed {
        logic             busy;
        logic             ch;
        logic [CNT_W-1:0] rem;
    } snd_st_t;

    snd_st_t          st_d, st_q;
    logic [CNT_W-1:0] eff;

    always_comb begin
        st_d = st_q;
        pop  = '0;
        done = '0;
        eff  = '0;
        if (st_q.busy) begin
            if (tx_ready) begin
                pop[st_q.ch] = 1'b1;
                st_d.rem     = st_q.rem - CNT_W'(1);
                if (st_q.rem == CNT_W'(1)) begin
                    done[st_q.ch] = 1'b1;
                    st_d.busy     = 1'b0;
                end
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (send_req[c]) begin
                    eff = (len[c] < held[c]) ? len[c] : held[c];
                    if (eff != '0) begin
                        st_d.busy = 1'b1;
                        st_d.ch   = 1'(c);
                        st_d.rem  = eff;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid = st_q.busy;
    assign tx_data  = head[st_q.ch];
    assign cur_ch   = st_q.ch;

endmodule

// File: rtl/dual_tx_fifo.sv
module dual_tx_fifo
    import dtx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        irq
);

    typedef struct packed {
        logic                      en;
        logic                      chsel;
        logic [NCH-1:0][CNT_W-1:0] len;
        logic [NCH-1:0]            ien;
        logic [NCH-1:0]            sta;
    } top_st_t;

    top_st_t                   st_d, st_q;
    logic [NCH-1:0]            push_w;
    logic [NCH-1:0]            send_w;
    logic [NCH-1:0]            pop_w;
    logic [NCH-1:0]            done_w;
    logic [NCH-1:0][CNT_W-1:0] cnt_w;
    logic [NCH-1:0][7:0]       head_w;
    logic                      cur_ch_w;
    logic                      en_w;
    logic [NCH-1:0]            sta_w;
    logic [3:0]                len_addr;
    logic [3:0]                send_addr;

    always_comb begin
        st_d      = st_q;
        push_w    = '0;
        send_w    = '0;
        len_addr  = '0;
        send_addr = '0;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL:  st_d.en    = wr_data[0];
                A_CHSEL: st_d.chsel = (wr_data < 32'd2) ? wr_data[0] : 1'b0;
                A_IEN:   st_d.ien   = wr_data[NCH-1:0];
                A_ICLR:  st_d.sta   = st_q.sta & ~wr_data[NCH-1:0];
                default: ;
            endcase
        end
        for (int c = 0; c < NCH; c++) begin
            len_addr  = (c == 0) ? A_LEN0 : A_LEN1;
            send_addr = (c == 0) ? A_SEND0 : A_SEND1;
            if (wr_en && wr_addr == len_addr) begin
                st_d.len[c] = (wr_data > 32'(DEPTH)) ? CNT_W'(DEPTH)
                                                     : wr_data[CNT_W-1:0];
            end
            push_w[c] = wr_en && (wr_addr == A_DATA) && (st_q.chsel == 1'(c));
            send_w[c] = wr_en && (wr_addr == send_addr) && wr_data[0] && st_q.en;
            if (done_w[c]) begin
                st_d.len[c] = '0;
                st_d.sta[c] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chan
            dtx_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (push_w[g]),
                .push_word (wr_data),
                .pop       (pop_w[g]),
                .flush     (done_w[g]),
                .head      (head_w[g]),
                .count     (cnt_w[g])
            );
        end
    endgenerate

    dtx_sender #(.CNT_W(CNT_W)) u_sender (
        .clk      (clk),
        .rst_n    (rst_n),
        .send_req (send_w),
        .len      (st_q.len),
        .held     (cnt_w),
        .head     (head_w),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .pop      (pop_w),
        .done     (done_w),
        .cur_ch   (cur_ch_w)
    );

    assign en_w  = st_q.en;
    assign sta_w = st_q.sta;
    assign irq   = |(st_q.sta & st_q.ien);

endmodule

// File: rtl/dtx_chk.sv
module dtx_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tx_valid,
    input logic                  tx_ready,
    input logic [7:0]            tx_data,
    input logic [1:0]            done,
    input logic                  cur_ch,
    input logic                  en,
    input logic [1:0]            sta,
    input logic [1:0][CNT_W-1:0] cnt
);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R7
    sta0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done[0] |=> sta[0]);

    // R7
    sta1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done[1] |=> sta[1]);

    // R9
    ch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && (done == 2'b00)) |=> (tx_valid && $stable(cur_ch)));

    // R5
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && !en) |=> !tx_valid);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[0] <= CNT_W'(DEPTH)) && (cnt[1] <= CNT_W'(DEPTH)));

endmodule

bind dual_tx_fifo dtx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .done     (done_w),
    .cur_ch   (cur_ch_w),
    .en       (en_w),
    .sta      (sta_w),
    .cnt      (cnt_w)
);

// File: tb/tb_dual_tx_fifo.sv
module tb_dual_tx_fifo;
    import dtx_pkg::*;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        irq;

    int          n_chk = 0;
    int          n_bad = 0;
    string       cur_req = "R11";
    int          rdy_mode = 0;
    int          rcnt = 0;

    logic [7:0]  exp_q[$];
    logic [7:0]  mq0[$];
    logic [7:0]  mq1[$];
    logic        m_en = 1'b0;
    logic        m_ch = 1'b0;
    int          m_len[2];
    logic [1:0]  m_ien = '0;
    logic [1:0]  m_sta = '0;

    dual_tx_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_valid(tx_valid), .irq(irq)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        #1;
        rcnt = rcnt + 1;
        case (rdy_mode)
            0: tx_ready = 1'b1;
            1: tx_ready = rcnt[0] ^ rcnt[2];
            default: tx_ready = 1'b0;
        endcase
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                chk(cur_req, {24'h0, tx_data}, 32'hDEAD);
            end else begin
                chk(cur_req, {24'h0, tx_data}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    // driver with reference model
    task automatic wr(input reg_addr_e a, input logic [31:0] d);
        int n;
        int c;
        case (a)
            A_CTRL:  m_en = d[0];
            A_CHSEL: m_ch = (d < 2) ? d[0] : 1'b0;
            A_LEN0:  m_len[0] = (d > DEPTH) ? DEPTH : int'(d);
            A_LEN1:  m_len[1] = (d > DEPTH) ? DEPTH : int'(d);
            A_DATA: begin
                if (m_ch == 1'b0 && mq0.size() + 4 <= DEPTH)
                    for (int k = 0; k < 4; k++) mq0.push_back(d[8*k +: 8]);
                if (m_ch == 1'b1 && mq1.size() + 4 <= DEPTH)
                    for (int k = 0; k < 4; k++) mq1.push_back(d[8*k +: 8]);
            end
            A_SEND0, A_SEND1: begin
                c = (a == A_SEND0) ? 0 : 1;
                if (d[0] && m_en) begin
                    n = (c == 0) ? mq0.size() : mq1.size();
                    if (m_len[c] < n) n = m_len[c];
                    if (n > 0) begin
                        for (int i = 0; i < n; i++)
                            exp_q.push_back((c == 0) ? mq0[i] : mq1[i]);
                        if (c == 0) mq0.delete(); else mq1.delete();
                        m_len[c] = 0;
                        m_sta[c] = 1'b1;
                    end
                end
            end
            A_IEN:  m_ien = d[1:0];
            A_ICLR: m_sta = m_sta & ~d[1:0];
            default: ;
        endcase
        wr_raw(a, d);
    endtask

    task automatic wr_raw(input reg_addr_e a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) begin
            @(posedge clk); #1;
        end
        chk(req, exp_q.size(), 0);
        repeat (3) @(posedge clk);
        #1;
        chk(req, {31'h0, tx_valid}, 0);
        chk(req, {31'h0, irq}, {31'h0, |(m_sta & m_ien)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_len[0] = 0; m_len[1] = 0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R11 reset state
        chk("R11", {31'h0, tx_valid}, 0);
        chk("R11", {31'h0, irq}, 0);

        // R1 basic frame, byte order, length shorter than held
        cur_req = "R1";
        wr(A_CTRL, 1); wr(A_IEN, 3);
        wr(A_DATA, 32'h44332211); wr(A_DATA, 32'h88776655);
        wr(A_LEN0, 6); wr(A_SEND0, 1);
        drain("R1");
        // R7 status set, length cleared and buffer flushed
        chk("R7", {31'h0, irq}, 1);
        wr(A_ICLR, 1);
        chk("R8", {31'h0, irq}, 0);
        cur_req = "R7";
        wr(A_SEND0, 1);
        repeat (8) @(posedge clk);
        #1;
        chk("R7", {31'h0, tx_valid}, 0);
        chk("R7", {31'h0, irq}, 0);

        // R3 channel select clamp, channels independent
        cur_req = "R3";
        wr(A_CHSEL, 1); wr(A_DATA, 32'hA4A3A2A1);
        wr(A_CHSEL, 5); wr(A_DATA, 32'hB4B3B2B1);
        wr(A_LEN0, 4); wr(A_SEND0, 1);
        drain("R3");
        rdy_mode = 1;
        wr(A_LEN1, 4); wr(A_SEND1, 1);
        drain("R3");
        wr(A_ICLR, 3);

        // R2 overfill dropped, R4 length clamp
        cur_req = "R4";
        wr(A_CHSEL, 1);
        wr(A_DATA, 32'h03020100); wr(A_DATA, 32'h07060504);
        wr(A_DATA, 32'h0B0A0908); wr(A_DATA, 32'h0F0E0D0C);
        wr(A_DATA, 32'hEEEEEEEE);
        wr(A_LEN1, 100); wr(A_SEND1, 1);
        drain("R2");

        // R6 length above held, and zero length
        cur_req = "R6";
        wr(A_CHSEL, 0);
        wr(A_DATA, 32'h5A5B5C5D); wr(A_DATA, 32'h1E2E3E4E);
        wr(A_ICLR, 3);
        wr(A_LEN0, 0); wr(A_SEND0, 1);
        repeat (8) @(posedge clk);
        #1;
        chk("R6", {31'h0, tx_valid}, 0);
        chk("R6", {31'h0, irq}, 0);
        wr(A_LEN0, 12); wr(A_SEND0, 1);
        drain("R6");
        wr(A_ICLR, 3);

        // R5 enable gates send
        cur_req = "R5";
        wr(A_CTRL, 0);
        wr(A_DATA, 32'hC4C3C2C1); wr(A_LEN0, 4); wr(A_SEND0, 1);
        repeat (8) @(posedge clk);
        #1;
        chk("R5", {31'h0, tx_valid}, 0);
        chk("R5", {31'h0, irq}, 0);
        wr(A_CTRL, 1); wr(A_SEND0, 1);
        drain("R5");
        wr(A_ICLR, 3);

        // R9 send on other channel while busy is ignored
        cur_req = "R9";
        rdy_mode = 2;
        wr(A_DATA, 32'hD4D3D2D1); wr(A_DATA, 32'hD8D7D6D5);
        wr(A_LEN0, 8); wr(A_SEND0, 1);
        wr(A_CHSEL, 1); wr(A_DATA, 32'hF4F3F2F1); wr(A_LEN1, 4);
        wr_raw(A_SEND1, 1);
        #1;
        chk("R10", {31'h0, tx_valid}, 1);
        chk("R10", {24'h0, tx_data}, 32'hD1);
        rdy_mode = 1;
        drain("R9");
        wr(A_IEN, 2);
        chk("R9", {31'h0, irq}, 0);
        wr(A_SEND1, 1);
        drain("R9");

        // R8 masking and write-one-to-clear per bit
        cur_req = "R8";
        chk("R8", {31'h0, irq}, 1);
        wr(A_IEN, 0);
        chk("R8", {31'h0, irq}, 0);
        wr(A_IEN, 1);
        chk("R8", {31'h0, irq}, 1);
        wr(A_ICLR, 1);
        chk("R8", {31'h0, irq}, 0);
        wr(A_IEN, 2);
        chk("R8", {31'h0, irq}, 1);
        wr(A_ICLR, 2);
        chk("R8", {31'h0, irq}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule